// File: doc/BRIEF.md
# Multi-mode effective address unit

This block resolves where an instruction's operand lives. A decoder hands it an addressing mode, the instruction's address field, a register number and the current program counter. The unit returns one of three things: a literal value, a register index, or a memory address. Modes that need memory contents to finish the calculation, such as pointer chains and pointer-plus-index forms, read memory through a request/valid port one word per step. Modes that need no memory read finish one cycle after the start pulse.

The unit holds an eight-entry, 16-bit register file that supplies the register operands. A write port loads this file. The auto-incrementing indexed mode bumps one of its entries. When segmentation is built in, each address result is turned into a wider physical address: a 16-bit segment value is shifted left by four bits and the 16-bit offset is added to it. Memory reads made during a walk use the unsegmented 16-bit offsets.

Inputs are taken only on a start pulse that arrives while the unit is idle. A one-cycle `done` pulse marks a valid result on `ea_out` and `ea_kind`. That result is held until the next completion.

Top module: `ea_unit`

## Requirements
- R1: Mode code 0 (immediate) completes with `done` high in the cycle after the accepted start. It gives `ea_kind` = 0 (literal value) and `ea_out` = zero-extended field A, and it issues no memory request.
- R2: Mode code 1 (direct) completes in the cycle after start with `ea_kind` = 1 (address) and the address A. Codes 10 to 15 behave as direct. Code 2 with depth 0 also behaves as direct.
- R3: Mode code 3 (register) completes in the cycle after start with `ea_kind` = 2 (register index) and `ea_out` = the zero-extended register number.
- R4: Mode code 4 (register indirect) completes in the cycle after start with the address equal to the contents of the selected register. It makes no memory read.
- R5: Mode code 5 (displacement) gives A + register contents. Mode code 6 (PC-relative) gives A + PC. Both wrap modulo 2^16 and complete in the cycle after start.
- R6: Mode code 7 (indexed with auto-increment) gives A + the register's old value in the cycle after start. The selected register holds its old value plus one (mod 2^16) from the `done` cycle onward.
- R7: Mode code 2 with depth d of 1 to 3 reads memory first at A and then at each word returned, d reads in all. The address is the last word read, and `done` rises in the cycle after the last accepted read.
- R8: Mode code 8 (post-indexed) reads memory at A and gives the word read plus the register's contents as they were at start.
- R9: Mode code 9 (pre-indexed) reads memory at A + register contents and gives the word read as the address.
- R10: `mem_req` stays high with a stable `mem_addr` until `mem_valid` is seen. `busy` is high from the cycle after a walking start until the cycle of `done`. A start pulse that arrives while `busy` is high is ignored. After reset, `done`, `busy`, `mem_req` and `ea_out` are all zero.
- R11: With segmentation built in, address results (`ea_kind` = 1) are output as (segment << 4) + offset modulo 2^20, using the segment sampled at start. Literal and register results are not segmented.
- R12: A register write (`rf_we`) stores `rf_wdata` in entry `rf_waddr`. When an auto-increment targets the same entry in the same cycle, the increment wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a resolution; inputs sampled when idle |
| mode | input | 4 | Addressing mode code |
| field_a | input | 16 | Instruction address/operand field |
| reg_sel | input | 3 | Register number |
| pc | input | 16 | Current program counter |
| depth | input | 2 | Indirection levels for mode 2 |
| seg_val | input | 16 | Segment value for physical address formation |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | 3 | Register file write index |
| rf_wdata | input | 16 | Register file write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_valid | input | 1 | Read data valid; completes the current read |
| mem_data | input | 16 | Read data |
| busy | output | 1 | A memory walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| ea_kind | output | 2 | 0 literal, 1 address, 2 register index |
| ea_out | output | 20 | Result value, address or register index |

## Verification
Modes that do not touch memory must show `done` and their result exactly one cycle after the start edge. A walk of d reads with L wait cycles per read must show `done` at cycle d*(L+1)+1, counted from the start edge. The bench samples on the falling edge and counts cycles from the start edge. It fails any run where `done` appears earlier or later than that count, and it checks the value only in the `done` cycle. The bench's memory responder compares each accepted read address against a queue of expected addresses. Register side effects are read back one resolution later through register-indirect mode.

// File: rtl/ea_pkg.sv
package ea_pkg;
   localparam logic [3:0] AM_IMM    = 4'd0;
   localparam logic [3:0] AM_DIR    = 4'd1;
   localparam logic [3:0] AM_IND    = 4'd2;
   localparam logic [3:0] AM_REG    = 4'd3;
   localparam logic [3:0] AM_RIND   = 4'd4;
   localparam logic [3:0] AM_DISP   = 4'd5;
   localparam logic [3:0] AM_PCREL  = 4'd6;
   localparam logic [3:0] AM_IDXINC = 4'd7;
   localparam logic [3:0] AM_POSTIX = 4'd8;
   localparam logic [3:0] AM_PREIX  = 4'd9;

   typedef enum logic [1:0] {
      K_VAL  = 2'd0,
      K_ADDR = 2'd1,
      K_REG  = 2'd2
   } res_kind_e;
endpackage

// File: rtl/ea_regfile.sv
module ea_regfile #(
   parameter int DW   = 16,
   parameter int NREG = 8,
   localparam int RIW = $clog2(NREG)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [RIW-1:0] rd_idx,
   output logic [DW-1:0]  rd_data,
   input  logic           wr_en,
   input  logic [RIW-1:0] wr_idx,
   input  logic [DW-1:0]  wr_data,
   input  logic           inc_en,
   input  logic [RIW-1:0] inc_idx
);
   logic [DW-1:0] rd_arr [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_ent
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (inc_en && inc_idx == RIW'(i)) begin
            q <= q + DW'(1);
         end else if (wr_en && wr_idx == RIW'(i)) begin
            q <= wr_data;
         end
      end
      assign rd_arr[i] = q;
   end

   assign rd_data = rd_arr[rd_idx];
endmodule

// File: rtl/ea_physmap.sv
module ea_physmap
   import ea_pkg::*;
#(
   parameter int DW        = 16,
   parameter int SEG_SHIFT = 4,
   parameter bit USE_SEG   = 1'b1,
   localparam int PW       = USE_SEG ? DW + SEG_SHIFT : DW
) (
   input  logic [DW-1:0] offset,
   input  logic [DW-1:0] seg,
   input  res_kind_e     kind,
   output logic [PW-1:0] pa
);
   if (USE_SEG) begin : g_seg
      logic [PW-1:0] base;
      assign base = PW'({seg, {SEG_SHIFT{1'b0}}});
      assign pa   = (kind == K_ADDR) ? base + PW'(offset) : PW'(offset);
   end else begin : g_flat
      assign pa = offset;
   end
endmodule

// File: rtl/ea_seq.sv
module ea_seq
   import ea_pkg::*;
#(
   parameter int DW      = 16,
   parameter int RIW     = 3,
   parameter int DEPTH_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [3:0]         mode,
   input  logic [DW-1:0]      field_a,
   input  logic [RIW-1:0]     reg_idx,
   input  logic [DW-1:0]      pc,
   input  logic [DEPTH_W-1:0] depth,
   input  logic [DW-1:0]      rval,
   output logic               mem_req,
   output logic [DW-1:0]      mem_addr,
   input  logic               mem_valid,
   input  logic [DW-1:0]      mem_data,
   output logic               accept,
   output logic               busy,
   output logic               done,
   output res_kind_e          kind,
   output logic [DW-1:0]      ea,
   output logic               inc_en,
   output logic [RIW-1:0]     inc_idx
);
   typedef enum logic {S_IDLE, S_WALK} state_e;

   state_e               state;
   logic [DW-1:0]        addr_q, rsave_q, ea_q;
   logic [DEPTH_W-1:0]   lvl_q;
   logic                 post_q, done_q;
   res_kind_e            kind_q;

   logic                 walk_n;
   logic [DW-1:0]        ea_n, waddr_n;
   logic [DEPTH_W-1:0]   wlvl_n;
   res_kind_e            kind_n;

   assign accept = start && (state == S_IDLE);

   always_comb begin
      walk_n  = 1'b0;
      ea_n    = field_a;
      kind_n  = K_ADDR;
      waddr_n = field_a;
      wlvl_n  = DEPTH_W'(1);
      case (mode)
         AM_IMM:    kind_n = K_VAL;
         AM_IND:    begin
            walk_n = (depth != '0);
            wlvl_n = depth;
         end
         AM_REG:    begin
            kind_n = K_REG;
            ea_n   = DW'(reg_idx);
         end
         AM_RIND:   ea_n = rval;
         AM_DISP,
         AM_IDXINC: ea_n = field_a + rval;
         AM_PCREL:  ea_n = field_a + pc;
         AM_POSTIX: walk_n = 1'b1;
         AM_PREIX:  begin
            walk_n  = 1'b1;
            waddr_n = field_a + rval;
         end
         default:   ea_n = field_a;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         addr_q  <= '0;
         rsave_q <= '0;
         ea_q    <= '0;
         lvl_q   <= '0;
         post_q  <= 1'b0;
         done_q  <= 1'b0;
         kind_q  <= K_VAL;
      end else begin
         done_q <= 1'b0;
         case (state)
            S_IDLE: if (accept) begin
               if (walk_n) begin
                  state   <= S_WALK;
                  addr_q  <= waddr_n;
                  lvl_q   <= wlvl_n;
                  post_q  <= (mode == AM_POSTIX);
                  rsave_q <= rval;
               end else begin
                  done_q <= 1'b1;
                  ea_q   <= ea_n;
                  kind_q <= kind_n;
               end
            end
            S_WALK: if (mem_valid) begin
               if (lvl_q == DEPTH_W'(1)) begin
                  state  <= S_IDLE;
                  done_q <= 1'b1;
                  kind_q <= K_ADDR;
                  ea_q   <= post_q ? mem_data + rsave_q : mem_data;
               end else begin
                  addr_q <= mem_data;
                  lvl_q  <= lvl_q - DEPTH_W'(1);
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign mem_req  = (state == S_WALK);
   assign mem_addr = addr_q;
   assign busy     = (state == S_WALK);
   assign done     = done_q;
   assign kind     = kind_q;
   assign ea       = ea_q;
   assign inc_en   = accept && (mode == AM_IDXINC);
   assign inc_idx  = reg_idx;
endmodule

// File: rtl/ea_unit.sv
module ea_unit
   import ea_pkg::*;
#(
   parameter int DW        = 16,
   parameter int NREG      = 8,
   parameter int DEPTH_W   = 2,
   parameter bit USE_SEG   = 1'b1,
   parameter int SEG_SHIFT = 4,
   localparam int RIW      = $clog2(NREG),
   localparam int PW       = USE_SEG ? DW + SEG_SHIFT : DW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [3:0]         mode,
   input  logic [DW-1:0]      field_a,
   input  logic [RIW-1:0]     reg_sel,
   input  logic [DW-1:0]      pc,
   input  logic [DEPTH_W-1:0] depth,
   input  logic [DW-1:0]      seg_val,
   input  logic               rf_we,
   input  logic [RIW-1:0]     rf_waddr,
   input  logic [DW-1:0]      rf_wdata,
   output logic               mem_req,
   output logic [DW-1:0]      mem_addr,
   input  logic               mem_valid,
   input  logic [DW-1:0]      mem_data,
   output logic               busy,
   output logic               done,
   output logic [1:0]         ea_kind,
   output logic [PW-1:0]      ea_out
);
   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("ea_unit: NREG must be a power of two, at least 2");
   end
   if (DW < 8) begin : g_bad_dw
      $error("ea_unit: DW must be at least 8");
   end
   if (DEPTH_W < 1) begin : g_bad_depth
      $error("ea_unit: DEPTH_W must be at least 1");
   end

   logic [DW-1:0]  rval, ea_off;
   logic           accept, inc_en;
   logic [RIW-1:0] inc_idx;
   res_kind_e      kind;
   logic [DW-1:0]  seg_q;

   ea_regfile #(.DW(DW), .NREG(NREG)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (reg_sel),
      .rd_data (rval),
      .wr_en   (rf_we),
      .wr_idx  (rf_waddr),
      .wr_data (rf_wdata),
      .inc_en  (inc_en),
      .inc_idx (inc_idx)
   );

   ea_seq #(.DW(DW), .RIW(RIW), .DEPTH_W(DEPTH_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mode      (mode),
      .field_a   (field_a),
      .reg_idx   (reg_sel),
      .pc        (pc),
      .depth     (depth),
      .rval      (rval),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .mem_valid (mem_valid),
      .mem_data  (mem_data),
      .accept    (accept),
      .busy      (busy),
      .done      (done),
      .kind      (kind),
      .ea        (ea_off),
      .inc_en    (inc_en),
      .inc_idx   (inc_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      seg_q <= '0;
      else if (accept) seg_q <= seg_val;
   end

   ea_physmap #(.DW(DW), .SEG_SHIFT(SEG_SHIFT), .USE_SEG(USE_SEG)) u_pm (
      .offset (ea_off),
      .seg    (seg_q),
      .kind   (kind),
      .pa     (ea_out)
   );

   assign ea_kind = kind;
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
   parameter int DW        = 16,
   parameter int RIW       = 3,
   parameter bit USE_SEG   = 1'b1,
   parameter int SEG_SHIFT = 4,
   parameter int PW        = 20
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [3:0]     mode,
   input logic [DW-1:0]  field_a,
   input logic [RIW-1:0] reg_sel,
   input logic [DW-1:0]  seg_val,
   input logic           busy,
   input logic           done,
   input logic [1:0]     ea_kind,
   input logic [PW-1:0]  ea_out,
   input logic           mem_req,
   input logic [DW-1:0]  mem_addr,
   input logic           mem_valid
);
   function automatic logic [PW-1:0] to_pa(input logic [DW-1:0] s, input logic [DW-1:0] o);
      if (USE_SEG) return PW'({s, {SEG_SHIFT{1'b0}}}) + PW'(o);
      else         return PW'(o);
   endfunction

   // R1: immediate returns the field as a literal, next cycle
   p_imm_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mode == 4'd0) |=> (done && ea_kind == 2'd0 && ea_out == PW'($past(field_a))));

   // R1: immediate makes no memory request
   p_imm_noreq_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mode == 4'd0) |=> !mem_req);

   // R2 and R11: direct address, segmented with the sampled segment
   p_dir_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mode == 4'd1) |=>
         (done && ea_kind == 2'd1 && ea_out == to_pa($past(seg_val), $past(field_a))));

   // R3: register mode reports the register number
   p_reg_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mode == 4'd3) |=> (done && ea_kind == 2'd2 && ea_out == PW'($past(reg_sel))));

   // R10: request held with stable address until valid
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

   // R10: a walk only begins from a start pulse
   p_busy_from_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R10: completion is never reported while still walking
   p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind ea_unit ea_unit_chk #(
   .DW(DW), .RIW(RIW), .USE_SEG(USE_SEG), .SEG_SHIFT(SEG_SHIFT), .PW(PW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .field_a(field_a),
   .reg_sel(reg_sel), .seg_val(seg_val), .busy(busy), .done(done),
   .ea_kind(ea_kind), .ea_out(ea_out), .mem_req(mem_req),
   .mem_addr(mem_addr), .mem_valid(mem_valid)
);

// File: tb/ea_unit_bench.sv
`timescale 1ns/1ps
module ea_unit_bench;
   import ea_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  mode = '0;
   logic [15:0] field_a = '0;
   logic [2:0]  reg_sel = '0;
   logic [15:0] pc = '0;
   logic [1:0]  depth = '0;
   logic [15:0] seg_val = '0;
   logic        rf_we = 1'b0;
   logic [2:0]  rf_waddr = '0;
   logic [15:0] rf_wdata = '0;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic        mem_valid = 1'b0;
   logic [15:0] mem_data = '0;
   logic        busy, done;
   logic [1:0]  ea_kind;
   logic [19:0] ea_out;

   ea_unit u_ea_unit (.*);

   always #5 clk = ~clk;

   int tests = 0;
   int fails = 0;
   int wlat = 0;
   int wcnt = 0;
   int cycles = 0;
   logic [15:0] mreg [8];
   logic [15:0] exp_addr_q [$];

   function automatic logic [15:0] mem_fn(input logic [15:0] a);
      return a * 16'h0157 + 16'h02B3;
   endfunction

   function automatic logic [19:0] to_pa(input logic [1:0] k, input logic [15:0] s, input logic [15:0] o);
      if (k == 2'd1) return {s, 4'h0} + {4'h0, o};
      return {4'h0, o};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // memory responder: valid after wlat wait cycles, checks each address
   always @(negedge clk) begin
      mem_valid = 1'b0;
      if (rst_n && mem_req) begin
         if (wcnt >= wlat) begin
            mem_valid = 1'b1;
            mem_data  = mem_fn(mem_addr);
            wcnt = 0;
            if (exp_addr_q.size() == 0) begin
               chk(1'b0, "R10", "unexpected read", {16'h0, mem_addr}, 32'h0);
            end else begin
               logic [15:0] ea_exp;
               ea_exp = exp_addr_q.pop_front();
               chk(mem_addr == ea_exp, "R7", "read address", {16'h0, mem_addr}, {16'h0, ea_exp});
            end
         end else begin
            wcnt++;
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL R10 watchdog: actual %0d expected %0d", cycles, 150000);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic wr_reg(input int idx, input logic [15:0] v);
      @(negedge clk);
      rf_we = 1'b1; rf_waddr = 3'(idx); rf_wdata = v;
      @(negedge clk);
      rf_we = 1'b0;
      mreg[idx] = v;
   endtask

   // one resolution; nreads memory reads expected; ghost pulses a start mid-walk;
   // collide drives a register write to the same entry in the start cycle
   task automatic run(input logic [3:0] m, input logic [15:0] a, input int r,
                      input logic [1:0] dep, input logic [15:0] seg,
                      input logic [1:0] ek, input logic [15:0] eoff, input int nreads,
                      input string req, input bit ghost = 1'b0, input bit collide = 1'b0);
      int n;
      int exp_n;
      logic [19:0] epa;
      exp_n = nreads * (wlat + 1) + 1;
      epa = to_pa(ek, seg, eoff);
      @(negedge clk);
      start = 1'b1; mode = m; field_a = a; reg_sel = 3'(r); depth = dep; seg_val = seg;
      if (collide) begin
         rf_we = 1'b1; rf_waddr = 3'(r); rf_wdata = 16'h5555;
      end
      @(negedge clk);
      start = 1'b0; rf_we = 1'b0;
      n = 1;
      while (!done && n < 60) begin
         if (ghost && n == 2) begin
            start = 1'b1; mode = AM_IMM; field_a = 16'hDEAD; seg_val = 16'h0F0F;
         end
         @(negedge clk);
         start = 1'b0;
         n++;
      end
      chk(done && n == exp_n, req, "done cycle", n, exp_n);
      chk(ea_kind == ek, req, "result kind", {30'h0, ea_kind}, {30'h0, ek});
      chk(ea_out == epa, req, "result", {12'h0, ea_out}, {12'h0, epa});
      chk(exp_addr_q.size() == 0, req, "reads outstanding", exp_addr_q.size(), 0);
      if (ghost) begin
         @(negedge clk);
         chk(!done, "R10", "no second done after ignored start", {31'h0, done}, 0);
      end
      exp_addr_q.delete();
   endtask

   initial begin
      logic [15:0] p, q;
      repeat (3) @(negedge clk);
      chk(!done && !busy && !mem_req && ea_out == 0, "R10", "reset state",
          {29'h0, done, busy, mem_req}, 0);
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) wr_reg(i, 16'h1000 + 16'(i) * 16'h0123);
      wr_reg(7, 16'hFFFF);

      // R1 immediate
      run(AM_IMM, 16'hBEEF, 0, 0, 16'h0000, 2'd0, 16'hBEEF, 0, "R1");
      // R2 direct, unknown code, indirect depth 0
      run(AM_DIR, 16'h1234, 0, 0, 16'h0000, 2'd1, 16'h1234, 0, "R2");
      run(4'd12, 16'h0ABC, 0, 0, 16'h0000, 2'd1, 16'h0ABC, 0, "R2");
      run(AM_IND, 16'h0777, 0, 0, 16'h0000, 2'd1, 16'h0777, 0, "R2");
      // R3 register index
      run(AM_REG, 16'h4444, 5, 0, 16'h0000, 2'd2, 16'h0005, 0, "R3");
      // R4 register indirect; also shows the R12 write port loaded entry 2
      run(AM_RIND, 16'h0000, 2, 0, 16'h0000, 2'd1, mreg[2], 0, "R4");
      run(AM_RIND, 16'h0000, 6, 0, 16'h0000, 2'd1, mreg[6], 0, "R12");
      // R5 displacement, wrap, PC-relative
      pc = 16'h4000;
      run(AM_DISP, 16'h0010, 3, 0, 16'h0000, 2'd1, 16'h0010 + mreg[3], 0, "R5");
      run(AM_DISP, 16'h0002, 7, 0, 16'h0000, 2'd1, 16'h0001, 0, "R5");
      run(AM_PCREL, 16'hFFF0, 0, 0, 16'h0000, 2'd1, 16'h3FF0, 0, "R5");
      // R6 auto-increment indexed, then read back the register
      run(AM_IDXINC, 16'h0100, 4, 0, 16'h0000, 2'd1, 16'h0100 + mreg[4], 0, "R6");
      mreg[4] = mreg[4] + 16'h1;
      run(AM_RIND, 16'h0000, 4, 0, 16'h0000, 2'd1, mreg[4], 0, "R6");
      run(AM_IDXINC, 16'h0003, 7, 0, 16'h0000, 2'd1, 16'h0002, 0, "R6");
      mreg[7] = 16'h0000;
      run(AM_RIND, 16'h0000, 7, 0, 16'h0000, 2'd1, 16'h0000, 0, "R6");
      // R7 indirect chains at two latencies
      for (int lat = 0; lat <= 2; lat += 2) begin
         wlat = lat;
         for (int d = 1; d <= 3; d++) begin
            p = 16'h0200 + 16'(d);
            for (int k = 0; k < d; k++) begin
               exp_addr_q.push_back(p);
               p = mem_fn(p);
            end
            run(AM_IND, 16'h0200 + 16'(d), 0, 2'(d), 16'h0000, 2'd1, p, d, "R7");
         end
      end
      // R8 post-indexed
      wlat = 1;
      exp_addr_q.push_back(16'h0321);
      run(AM_POSTIX, 16'h0321, 1, 0, 16'h0000, 2'd1, mem_fn(16'h0321) + mreg[1], 1, "R8");
      // R9 pre-indexed
      q = 16'h0050 + mreg[5];
      exp_addr_q.push_back(q);
      run(AM_PREIX, 16'h0050, 5, 0, 16'h0000, 2'd1, mem_fn(q), 1, "R9");
      // R10 start during a walk is ignored
      wlat = 2;
      p = 16'h0A00;
      for (int k = 0; k < 3; k++) begin
         exp_addr_q.push_back(p);
         p = mem_fn(p);
      end
      run(AM_IND, 16'h0A00, 0, 2'd3, 16'h0000, 2'd1, p, 3, "R10", 1'b1);
      // R11 segmentation
      wlat = 0;
      run(AM_DIR, 16'h2359, 0, 0, 16'h490B, 2'd1, 16'h2359, 0, "R11");
      chk(ea_out == 20'h4B409, "R11", "segment example one", {12'h0, ea_out}, 32'h4B409);
      run(AM_DIR, 16'h8230, 0, 0, 16'h7800, 2'd1, 16'h8230, 0, "R11");
      chk(ea_out == 20'h80230, "R11", "segment example two", {12'h0, ea_out}, 32'h80230);
      run(AM_DIR, 16'h0020, 0, 0, 16'hFFFF, 2'd1, 16'h0020, 0, "R11");
      chk(ea_out == 20'h00010, "R11", "segment wrap", {12'h0, ea_out}, 32'h00010);
      run(AM_IMM, 16'h0042, 0, 0, 16'h1234, 2'd0, 16'h0042, 0, "R11");
      run(AM_REG, 16'h0000, 6, 0, 16'h1234, 2'd2, 16'h0006, 0, "R11");
      // R12 auto-increment wins over a same-cycle write
      run(AM_IDXINC, 16'h0000, 1, 0, 16'h0000, 2'd1, mreg[1], 0, "R12", 1'b0, 1'b1);
      mreg[1] = mreg[1] + 16'h1;
      run(AM_RIND, 16'h0000, 1, 0, 16'h0000, 2'd1, mreg[1], 0, "R12");

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule